// File: doc/BRIEF.md
# Receive Frame Packer and Word Reader

This block takes incoming Ethernet frames as a byte stream and lays each one down in a circular byte store with a fixed framing. Every stored packet begins with a marker word and a header word that holds the length and a status code. The frame bytes follow, zero-filled up to the 60-byte minimum. A 4-byte frame check sequence comes next, then zero bytes up to the next word boundary. A frame is only taken when receive is enabled and enough room is free; otherwise it is drained from the input and thrown away whole.

The host empties the store one 32-bit word per read request. The reader parses the header of each packet so that it knows where the packet ends. It keeps a count of complete packets, and a single receive interrupt status bit, masked by an enable bit, drives the interrupt line.

The packer runs a state machine with states P_IDLE (admission decision), P_DATA (frame bytes), P_PAD (minimum-size fill), P_FCS (check bytes), P_ALIGN (word fill), P_HDR (header word), P_MAGIC (marker word and commit) and P_DROP (discard). Its transitions are:
- P_IDLE to P_DATA when the frame is admitted, or to P_DROP when it is refused.
- P_DATA to P_PAD on the last byte of a frame shorter than 60 bytes, otherwise to P_FCS.
- P_PAD to P_FCS once 60 bytes are reached.
- P_FCS to P_ALIGN when the stored length is not yet word aligned, otherwise to P_HDR.
- P_ALIGN to P_HDR at the word boundary.
- P_HDR to P_MAGIC, and P_MAGIC to P_IDLE.
- P_DROP to P_IDLE on the last byte.

The reader cycles through R_MAGIC to R_HDR to R_BODY, and returns to R_MAGIC after the final body word.

Top module: `rfp_rx_top`

## Requirements
- R1: A frame is admitted only if `rx_en` is high and the free space is at least RESERVE bytes (default 1532 of a 2048-byte store) when its first byte is offered. A refused frame is still consumed through `in_ready` and leaves no trace in the store.
- R2: A refused frame increments `drop_count` only when `rx_en` is high. Frames offered with `rx_en` low are not counted.
- R3: A stored packet reads back in this order:
  - the marker word (default 32'hC0DE_0143);
  - the header word;
  - the frame bytes;
  - zero bytes up to 60;
  - the 4 check bytes;
  - zero bytes up to a multiple of 4.

  Each word is little-endian: the byte at the lower address sits in bits 7:0.
- R4: Header bits 15:0 hold the padded length plus 4. Bits 31:16 hold the OK status 16'h0001.
- R5: The check value is the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, final inversion) over the frame bytes and the zero fill. It is stored least significant byte first.
- R6: Once a packet is fully stored, `pkt_count` rises by one and `int_status` is set.
- R7: A one-cycle `rd_req` presents the next stored word on `rd_data` in the following cycle. The read that returns a packet's last body word decrements `pkt_count`.
- R8: A `rd_req` while `pkt_count` is 0 returns 0 with a one-cycle `rd_err` and does not advance the read position.
- R9: `irq` is high exactly when `int_status` and the enable bit written through `int_en_we`/`int_en_wd` are both 1.
- R10: Writing `int_sta_we` with `int_sta_wd` = 1 clears `int_status`.
- R11: The store is circular, so a run of packets whose total size exceeds the depth reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte is taken on this edge when high with in_valid |
| rd_req | input | 1 | Read one word from the data register |
| rd_data | output | 32 | Word returned by the last read |
| rd_err | output | 1 | Last read found no packet |
| int_en_we | input | 1 | Write strobe for the interrupt enable bit |
| int_en_wd | input | 1 | Interrupt enable write value |
| int_sta_we | input | 1 | Write strobe for the interrupt status (write-1-to-clear) |
| int_sta_wd | input | 1 | Interrupt status write value |
| int_status | output | 1 | Receive interrupt status |
| irq | output | 1 | Interrupt request |
| pkt_count | output | CW | Complete packets held |
| drop_count | output | CW | Frames refused for lack of space |

## Verification
A wrong packer pointer or state shows up at the ports on the first read of the affected packet. The marker or header word comes back shifted, or the check bytes land in the wrong words. A mistracked reader length is less immediate: it surfaces one packet later, when the next marker word is misread or `pkt_count` fails to fall on the final body word. A space-accounting fault only appears once the store is nearly full, as a wrong `drop_count` or as a corrupted packet after the pointers wrap.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    typedef enum logic [2:0] {
        P_IDLE, P_DATA, P_PAD, P_FCS, P_ALIGN, P_HDR, P_MAGIC, P_DROP
    } pk_state_t;

    typedef enum logic [1:0] {
        R_MAGIC, R_HDR, R_BODY
    } rd_state_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // one byte of reflected CRC-32
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rfp_store.sv
module rfp_store #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int WORDS = DEPTH / 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic          word_mode,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-3:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            if (word_mode) begin
                mem[waddr[AW-1:2]] <= wdata;
            end else begin
                mem[waddr[AW-1:2]][8*waddr[1:0] +: 8] <= wdata[7:0];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rfp_packer.sv
module rfp_packer
    import rfp_pkg::*;
#(
    parameter int          AW        = 11,
    parameter int          RESERVE   = 1532,
    parameter int          MIN_LEN   = 60,
    parameter int          CW        = 8,
    parameter logic [31:0] MAGIC     = 32'hC0DE_0143,
    parameter logic [15:0] STATUS_OK = 16'h0001,
    localparam int         PW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic [PW-1:0] free_bytes,
    output logic          wr_en,
    output logic          wr_word,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic          commit,
    output logic [PW-1:0] base_ptr,
    output logic [CW-1:0] drop_count
);
    pk_state_t     state, nxt;
    logic [PW-1:0] ptr;
    logic [15:0]   cnt;
    logic [31:0]   crc;
    logic [1:0]    idx;
    logic          admit;
    logic [31:0]   fin;

    assign admit = rx_en && (free_bytes >= PW'(RESERVE));
    assign fin   = ~crc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            base_ptr   <= '0;
            cnt        <= '0;
            crc        <= '1;
            idx        <= '0;
            drop_count <= '0;
        end else begin
            unique case (state)
                P_IDLE: if (in_valid) begin
                    ptr <= base_ptr + PW'(8);
                    cnt <= '0;
                    crc <= '1;
                    idx <= '0;
                    if (!admit && rx_en) drop_count <= drop_count + 1'b1;
                end
                P_DATA: if (in_valid) begin
                    ptr <= ptr + 1'b1;
                    cnt <= cnt + 1'b1;
                    crc <= crc_step(crc, in_data);
                end
                P_PAD: begin
                    ptr <= ptr + 1'b1;
                    cnt <= cnt + 1'b1;
                    crc <= crc_step(crc, 8'h00);
                end
                P_FCS: begin
                    ptr <= ptr + 1'b1;
                    idx <= idx + 1'b1;
                end
                P_ALIGN: ptr <= ptr + 1'b1;
                P_MAGIC: base_ptr <= ptr;
                P_HDR, P_DROP: ;
                default: ;
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        in_ready = 1'b0;
        wr_en    = 1'b0;
        wr_word  = 1'b0;
        wr_addr  = ptr[AW-1:0];
        wr_data  = '0;
        commit   = 1'b0;
        unique case (state)
            P_IDLE: if (in_valid) nxt = admit ? P_DATA : P_DROP;
            P_DATA: begin
                in_ready = 1'b1;
                wr_en    = in_valid;
                wr_data  = {24'h0, in_data};
                if (in_valid && in_last)
                    nxt = ((cnt + 16'd1) < 16'(MIN_LEN)) ? P_PAD : P_FCS;
            end
            P_PAD: begin
                wr_en = 1'b1;
                if ((cnt + 16'd1) >= 16'(MIN_LEN)) nxt = P_FCS;
            end
            P_FCS: begin
                wr_en   = 1'b1;
                wr_data = {24'h0, fin[8*idx +: 8]};
                if (idx == 2'd3) nxt = (ptr[1:0] != 2'd3) ? P_ALIGN : P_HDR;
            end
            P_ALIGN: begin
                wr_en = 1'b1;
                if (ptr[1:0] == 2'd3) nxt = P_HDR;
            end
            P_HDR: begin
                wr_en   = 1'b1;
                wr_word = 1'b1;
                wr_addr = base_ptr[AW-1:0] + AW'(4);
                wr_data = {STATUS_OK, cnt + 16'd4};
                nxt     = P_MAGIC;
            end
            P_MAGIC: begin
                wr_en   = 1'b1;
                wr_word = 1'b1;
                wr_addr = base_ptr[AW-1:0];
                wr_data = MAGIC;
                commit  = 1'b1;
                nxt     = P_IDLE;
            end
            P_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) nxt = P_IDLE;
            end
            default: nxt = P_IDLE;
        endcase
    end
endmodule

// File: rtl/rfp_reader.sv
module rfp_reader
    import rfp_pkg::*;
#(
    parameter int  AW = 11,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          avail,
    input  logic [31:0]   word,
    output logic [31:0]   rd_data,
    output logic          rd_err,
    output logic [PW-1:0] rd_ptr,
    output logic          pkt_done
);
    rd_state_t   state, nxt;
    logic [15:0] remain;
    logic        take;

    assign take = rd_req && avail;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= R_MAGIC;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        pkt_done = 1'b0;
        unique case (state)
            R_MAGIC: if (take) nxt = R_HDR;
            R_HDR:   if (take) nxt = R_BODY;
            R_BODY:  if (take && remain <= 16'd4) begin
                pkt_done = 1'b1;
                nxt      = R_MAGIC;
            end
            default: nxt = R_MAGIC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
            rd_ptr  <= '0;
            remain  <= '0;
        end else begin
            rd_err <= 1'b0;
            if (take) begin
                rd_data <= word;
                rd_ptr  <= rd_ptr + PW'(4);
                if (state == R_HDR)  remain <= (word[15:0] + 16'd3) & 16'hFFFC;
                if (state == R_BODY) remain <= remain - 16'd4;
            end else if (rd_req) begin
                rd_data <= '0;
                rd_err  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfp_rx_top.sv
module rfp_rx_top #(
    parameter int          DEPTH     = 2048,
    parameter int          RESERVE   = 1532,
    parameter int          MIN_LEN   = 60,
    parameter int          CW        = 8,
    parameter logic [31:0] MAGIC     = 32'hC0DE_0143,
    parameter logic [15:0] STATUS_OK = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          rd_req,
    output logic [31:0]   rd_data,
    output logic          rd_err,
    input  logic          int_en_we,
    input  logic          int_en_wd,
    input  logic          int_sta_we,
    input  logic          int_sta_wd,
    output logic          int_status,
    output logic          irq,
    output logic [CW-1:0] pkt_count,
    output logic [CW-1:0] drop_count
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_en, wr_word, commit_w, done_w, int_en;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data, rd_word;
    logic [PW-1:0] base_ptr, rd_ptr, free_bytes;

    assign free_bytes = PW'(DEPTH) - (base_ptr - rd_ptr);

    rfp_packer #(
        .AW(AW), .RESERVE(RESERVE), .MIN_LEN(MIN_LEN), .CW(CW),
        .MAGIC(MAGIC), .STATUS_OK(STATUS_OK)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .free_bytes(free_bytes),
        .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit_w), .base_ptr(base_ptr), .drop_count(drop_count)
    );

    rfp_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(wr_en), .word_mode(wr_word), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_ptr[AW-1:2]), .rdata(rd_word)
    );

    rfp_reader #(.AW(AW)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .avail(pkt_count != '0),
        .word(rd_word), .rd_data(rd_data), .rd_err(rd_err), .rd_ptr(rd_ptr),
        .pkt_done(done_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_count  <= '0;
            int_en     <= 1'b0;
            int_status <= 1'b0;
        end else begin
            unique case ({commit_w, done_w})
                2'b10:   pkt_count <= pkt_count + 1'b1;
                2'b01:   pkt_count <= pkt_count - 1'b1;
                default: ;
            endcase
            if (int_en_we) int_en <= int_en_wd;
            if (commit_w)                      int_status <= 1'b1;
            else if (int_sta_we && int_sta_wd) int_status <= 1'b0;
        end
    end

    assign irq = int_status & int_en;
endmodule

// File: rtl/rfp_rx_chk.sv
module rfp_rx_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          commit,
    input logic          done,
    input logic [CW-1:0] pkt_count,
    input logic [CW-1:0] drop_count,
    input logic          rd_err,
    input logic [31:0]   rd_data,
    input logic          int_status,
    input logic          int_sta_we,
    input logic          int_sta_wd
);
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 32'h0) && ($past(pkt_count) == '0));

    // R6
    commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> int_status && (pkt_count != '0));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_count != $past(pkt_count)) |-> ($past(commit) || $past(done)));

    // R2
    drop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(rx_en));

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_sta_we && int_sta_wd && !commit) |=> !int_status);
endmodule

bind rfp_rx_top rfp_rx_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .commit(commit_w), .done(done_w),
    .pkt_count(pkt_count), .drop_count(drop_count), .rd_err(rd_err),
    .rd_data(rd_data), .int_status(int_status), .int_sta_we(int_sta_we),
    .int_sta_wd(int_sta_wd)
);

// File: tb/tb_rfp_rx_top.sv
module tb_rfp_rx_top;
    localparam logic [31:0] MAGIC_W = 32'hC0DE_0143;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b1;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        rd_err;
    logic        int_en_we = 1'b0, int_en_wd = 1'b0, int_sta_we = 1'b0, int_sta_wd = 1'b0;
    logic        int_status, irq;
    logic [7:0]  pkt_count, drop_count;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] eb [0:2047];

    always #4 clk = ~clk;

    rfp_rx_top dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .rd_req(rd_req), .rd_data(rd_data),
        .rd_err(rd_err), .int_en_we(int_en_we), .int_en_wd(int_en_wd),
        .int_sta_we(int_sta_we), .int_sta_wd(int_sta_wd), .int_status(int_status),
        .irq(irq), .pkt_count(pkt_count), .drop_count(drop_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB8_8320;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7) & 8'hFF);
    endfunction

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = pat(seed, i);
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_count(input int exp);
        for (int t = 0; t < 200 && pkt_count != 8'(exp); t++) @(negedge clk);
    endtask

    task automatic read_word();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // build expected bytes (R3, R4, R5), read packet and compare word by word
    task automatic read_frame(input int len, input int seed, input string tag);
        int plen = (len < 60) ? 60 : len;
        int body = ((plen + 4 + 3) / 4) * 4;
        int nw   = 2 + body / 4;
        logic [31:0] crc = 32'hFFFF_FFFF;
        logic [31:0] hdr = {16'h0001, 16'(plen + 4)};
        logic [7:0]  cnt0 = pkt_count;
        for (int i = 0; i < 8 + body; i++) eb[i] = 8'h00;
        for (int k = 0; k < 4; k++) begin
            eb[k]     = MAGIC_W[8*k +: 8];
            eb[4 + k] = hdr[8*k +: 8];
        end
        for (int i = 0; i < len; i++) eb[8 + i] = pat(seed, i);
        for (int i = 0; i < plen; i++) crc = ref_crc(crc, eb[8 + i]);
        crc = ~crc;
        for (int k = 0; k < 4; k++) eb[8 + plen + k] = crc[8*k +: 8];
        for (int w = 0; w < nw; w++) begin
            read_word();
            if (w == 0)      check({tag, " R3 marker"}, rd_data, MAGIC_W);
            else if (w == 1) check({tag, " R4 header"}, rd_data, hdr);
            else check({tag, " R3 R5 body"}, rd_data,
                       {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]});
            if (w < nw - 1) check({tag, " R7 count held"}, 32'(pkt_count), 32'(cnt0));
        end
        check({tag, " R7 count after last word"}, 32'(pkt_count), 32'(cnt0 - 8'd1));
    endtask

    task automatic t_reset();
        check("reset pkt_count", 32'(pkt_count), 0);
        check("reset drop_count", 32'(drop_count), 0);
        check("reset R9 irq", 32'(irq), 0);
        check("reset R6 int_status", 32'(int_status), 0);
    endtask

    task automatic t_empty_read();
        read_word();
        check("R8 empty data", rd_data, 0);
        check("R8 empty err", 32'(rd_err), 1);
        @(negedge clk);
        check("R8 err one cycle", 32'(rd_err), 0);
    endtask

    task automatic t_single(input int len, input int seed);
        send_frame(len, seed);
        wait_count(1);
        check("R6 count up", 32'(pkt_count), 1);
        check("R6 status set", 32'(int_status), 1);
        read_frame(len, seed, "single");
    endtask

    task automatic t_two_queued();
        send_frame(10, 3);
        send_frame(61, 40);
        wait_count(2);
        check("R6 two queued", 32'(pkt_count), 2);
        read_frame(10, 3, "queued first");
        read_frame(61, 40, "queued second");
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send_frame(30, 9);
        repeat (20) @(negedge clk);
        check("R1 disabled not stored", 32'(pkt_count), 0);
        check("R2 disabled not counted", 32'(drop_count), 0);
        rx_en = 1'b1;
        t_single(20, 11);
    endtask

    task automatic t_overflow();
        send_frame(600, 5);
        wait_count(1);
        send_frame(20, 77);
        repeat (20) @(negedge clk);
        check("R1 refused no store", 32'(pkt_count), 1);
        check("R2 refused counted", 32'(drop_count), 1);
        read_frame(600, 5, "R1 survivor");
        t_single(25, 13);
        check("R2 count steady", 32'(drop_count), 1);
    endtask

    task automatic t_wrap();
        for (int f = 0; f < 5; f++) begin
            send_frame(500, 20 + f);
            wait_count(1);
            read_frame(500, 20 + f, "R11 wrap");
        end
    endtask

    task automatic t_irq();
        send_frame(12, 1);
        wait_count(1);
        check("R9 masked", 32'(irq), 0);
        int_en_we = 1'b1; int_en_wd = 1'b1;
        @(negedge clk);
        int_en_we = 1'b0;
        check("R9 enabled", 32'(irq), 1);
        int_sta_we = 1'b1; int_sta_wd = 1'b0;
        @(negedge clk);
        int_sta_we = 1'b0;
        check("R10 write zero keeps", 32'(int_status), 1);
        int_sta_we = 1'b1; int_sta_wd = 1'b1;
        @(negedge clk);
        int_sta_we = 1'b0;
        check("R10 cleared", 32'(int_status), 0);
        check("R9 irq low", 32'(irq), 0);
        read_frame(12, 1, "irq frame");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_read();
        t_single(10, 1);
        t_single(60, 2);
        t_single(61, 3);
        t_single(62, 4);
        t_single(63, 5);
        t_two_queued();
        t_disabled();
        t_overflow();
        t_wrap();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule